// File: doc/BRIEF.md
# Serial Controller FIFO and Interrupt Unit

This block is the register-side data path of a serial controller. Software writes transmit words and reads receive words through one shared data address. Behind that address sit two FIFOs, one per direction, each 32 bits wide and 8 entries deep. The serial engine drains the transmit FIFO through a take handshake and fills the receive FIFO through a put strobe.

A FIFO control register holds a 4-bit threshold for each direction and a self-clearing flush bit for each direction. Three sticky interrupt sources are tracked: receive-complete (receive fill level reached the threshold), receive-overrun (a word arrived while the receive FIFO was full) and transmit-complete (transmit fill level drained to the threshold). Each source has an enable bit and a write-one-to-clear acknowledge. One level interrupt output combines them. Register offsets inside the 6-bit byte address space are 0x14 status, 0x18 interrupt enable, 0x1C interrupt status and clear, 0x20 FIFO control, and 0x24 data. Every other offset reads zero and ignores writes.

Top module: `ser_fifo_irq`

## Requirements
- R1: After reset both FIFOs are empty, `txAvail` and `irq` are 0, and registers 0x14, 0x18, 0x1C and 0x20 read 0.
- R2: A write to 0x24 pushes `wrData` into the transmit FIFO. The engine sees the words on `txHead` in write order while `txAvail` is 1, and pops one per cycle with `txTake`. A write while 8 words are held is dropped.
- R3: A read of 0x24 returns the oldest receive word and pops it. Bit 0 of 0x14 is 1 exactly when the receive FIFO is not empty. A read of 0x24 while it is empty returns 0 and disturbs nothing.
- R4: An engine put while 8 receive words are held drops the word, keeps the stored words, and sets overrun status (0x1C bit 0).
- R5: Receive-complete status (0x1C bit 3) is set by an accepted put that brings the receive level to at least the receive threshold (0x20 bits 3:0). It is never set while that threshold is 0.
- R6: Bit 9 of 0x1C reads 1 while the receive threshold is nonzero and the receive level is at least the threshold. It follows the level and is not sticky.
- R7: Transmit-complete status (0x1C bit 4) is set by a pop that leaves the transmit level at or below the transmit threshold (0x20 bits 11:8).
- R8: Status bits stay set until software writes 1 to bits 4, 3 or 0 of 0x1C. Zero bits in that write have no effect. A set in the same cycle as a clear wins.
- R9: `irq` is 1 exactly when some status bit among 4, 3 and 0 is set together with the same bit of the enable register 0x18.
- R10: Writing 1 to bit 12 of 0x20 empties the transmit FIFO, and writing 1 to bit 4 empties the receive FIFO, in one cycle. The same write loads both thresholds. The flush bits read back 0, and a flush beats a push in the same cycle.
- R11: Offsets other than 0x14, 0x18, 0x1C, 0x20 and 0x24 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a read of 0x24 pops) |
| addr | input | 6 | Byte address of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid in the cycle of `rdEn` |
| txAvail | output | 1 | Transmit FIFO holds a word |
| txHead | output | 32 | Oldest transmit word |
| txTake | input | 1 | Engine pops the transmit head |
| rxPut | input | 1 | Engine pushes a receive word |
| rxWord | input | 32 | Receive word from the engine |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are two events landing in the same clock edge. One is a flush write arriving with an engine put. The other is an overrun arriving with a clear write. Separate calls to the bus and engine tasks cannot line these up. Dedicated scenarios therefore raise `wrEn` and `rxPut` on the same falling edge. Afterwards they read the level flag and the status register to see which event won.

// File: rtl/sfi_pkg.sv
package sfi_pkg;
  localparam int ADDR_W = 6;
  localparam int THR_W  = 4;

  localparam logic [ADDR_W-1:0] A_STAT = 6'h14;
  localparam logic [ADDR_W-1:0] A_IEN  = 6'h18;
  localparam logic [ADDR_W-1:0] A_IST  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_FCTL = 6'h20;
  localparam logic [ADDR_W-1:0] A_DATA = 6'h24;

  // bit positions that software decodes
  localparam int B_OVR    = 0;
  localparam int B_RXDONE = 3;
  localparam int B_TXDONE = 4;
  localparam int B_THRLVL = 9;
  localparam int B_RXFL   = 4;
  localparam int B_TXFL   = 12;
  localparam int B_RXTHR  = 0;
  localparam int B_TXTHR  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } fifoCmd_t;
endpackage

// File: rtl/sfi_fifo.sv
module sfi_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CNT_W-1:0] level,
  output logic             pushOk,
  output logic             popOk,
  output logic             pushDrop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic full, empty;

  assign full     = (level == CNT_W'(DEPTH));
  assign empty    = (level == '0);
  assign pushOk   = push && !flush && !full;
  assign pushDrop = push && !flush && full;
  assign popOk    = pop && !flush && !empty;
  assign headData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   level <= level + CNT_W'(1);
        2'b01:   level <= level - CNT_W'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/sfi_datapath.sv
module sfi_datapath
  import sfi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoCmd_t          fifoCmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              txTake,
  input  logic              rxPut,
  input  logic [DATA_W-1:0] rxWord,
  output logic              txAvail,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txLevel,
  output logic [CNT_W-1:0]  rxLevel,
  output logic              rxPushOk,
  output logic              rxDrop,
  output logic              txPopOk
);
  logic txPushOk, txDrop, rxPopOk;

  sfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .flush(fifoCmd.txFlush),
    .push(fifoCmd.txPush), .pushData(wrData), .pop(txTake),
    .headData(txHead), .level(txLevel),
    .pushOk(txPushOk), .popOk(txPopOk), .pushDrop(txDrop)
  );

  sfi_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .flush(fifoCmd.rxFlush),
    .push(rxPut), .pushData(rxWord), .pop(fifoCmd.rxPop),
    .headData(rxHead), .level(rxLevel),
    .pushOk(rxPushOk), .popOk(rxPopOk), .pushDrop(rxDrop)
  );

  assign txAvail = (txLevel != '0);

  // accepted transmit pushes, dropped transmit pushes and receive pops
  // leave no sticky trace; only the level counters record them
  logic unusedEv;
  assign unusedEv = txPushOk ^ txDrop ^ rxPopOk;
endmodule

// File: rtl/sfi_control.sv
module sfi_control
  import sfi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxHead,
  input  logic [CNT_W-1:0]  txLevel,
  input  logic [CNT_W-1:0]  rxLevel,
  input  logic              rxPushOk,
  input  logic              rxDrop,
  input  logic              txPopOk,
  output fifoCmd_t          fifoCmd,
  output logic [2:0]        intStatus,
  output logic [2:0]        intEnable
);
  // intStatus / intEnable index: 2 = tx complete, 1 = rx complete, 0 = overrun
  logic [THR_W-1:0] txThr, rxThr;
  logic [2:0] setVec, clrVec;
  logic wrFctl, wrIen, wrIst, thrFlag;
  logic [CMP_W-1:0] rxLvlW, rxThrW, txLvlW, txThrW;

  assign wrFctl = wrEn && (addr == A_FCTL);
  assign wrIen  = wrEn && (addr == A_IEN);
  assign wrIst  = wrEn && (addr == A_IST);

  assign fifoCmd.txPush  = wrEn && (addr == A_DATA);
  assign fifoCmd.rxPop   = rdEn && (addr == A_DATA);
  assign fifoCmd.txFlush = wrFctl && wrData[B_TXFL];
  assign fifoCmd.rxFlush = wrFctl && wrData[B_RXFL];

  assign rxLvlW = CMP_W'(rxLevel);
  assign rxThrW = CMP_W'(rxThr);
  assign txLvlW = CMP_W'(txLevel);
  assign txThrW = CMP_W'(txThr);

  assign thrFlag = (rxThr != '0) && (rxLvlW >= rxThrW);

  assign setVec[0] = rxDrop;
  assign setVec[1] = rxPushOk && (rxThr != '0) && ((rxLvlW + CMP_W'(1)) >= rxThrW);
  assign setVec[2] = txPopOk && ((txLvlW - CMP_W'(1)) <= txThrW);

  assign clrVec = wrIst ? {wrData[B_TXDONE], wrData[B_RXDONE], wrData[B_OVR]} : 3'b000;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txThr     <= '0;
      rxThr     <= '0;
      intEnable <= '0;
      intStatus <= '0;
    end else begin
      if (wrFctl) begin
        txThr <= wrData[B_TXTHR +: THR_W];
        rxThr <= wrData[B_RXTHR +: THR_W];
      end
      if (wrIen) intEnable <= {wrData[B_TXDONE], wrData[B_RXDONE], wrData[B_OVR]};
      intStatus <= (intStatus & ~clrVec) | setVec;
    end
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        A_STAT: rdData[0] = (rxLevel != '0);
        A_IEN: begin
          rdData[B_TXDONE] = intEnable[2];
          rdData[B_RXDONE] = intEnable[1];
          rdData[B_OVR]    = intEnable[0];
        end
        A_IST: begin
          rdData[B_THRLVL] = thrFlag;
          rdData[B_TXDONE] = intStatus[2];
          rdData[B_RXDONE] = intStatus[1];
          rdData[B_OVR]    = intStatus[0];
        end
        A_FCTL: begin
          rdData[B_TXTHR +: THR_W] = txThr;
          rdData[B_RXTHR +: THR_W] = rxThr;
        end
        A_DATA: rdData = (rxLevel != '0) ? rxHead : '0;
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/ser_fifo_irq.sv
module ser_fifo_irq
  import sfi_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              txAvail,
  output logic [DATA_W-1:0] txHead,
  input  logic              txTake,
  input  logic              rxPut,
  input  logic [DATA_W-1:0] rxWord,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  fifoCmd_t fifoCmd;
  logic [DATA_W-1:0] rxHead;
  logic [CNT_W-1:0] txLevel, rxLevel;
  logic rxPushOk, rxDrop, txPopOk;
  logic [2:0] intStatus, intEnable;

  sfi_control #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxPushOk(rxPushOk),
    .rxDrop(rxDrop), .txPopOk(txPopOk), .fifoCmd(fifoCmd),
    .intStatus(intStatus), .intEnable(intEnable)
  );

  sfi_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .fifoCmd(fifoCmd), .wrData(wrData),
    .txTake(txTake), .rxPut(rxPut), .rxWord(rxWord),
    .txAvail(txAvail), .txHead(txHead), .rxHead(rxHead),
    .txLevel(txLevel), .rxLevel(rxLevel), .rxPushOk(rxPushOk),
    .rxDrop(rxDrop), .txPopOk(txPopOk)
  );

  assign irq = |(intStatus & intEnable);
endmodule

// File: rtl/sfi_checker.sv
module sfi_checker
  import sfi_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic              rxPut,
  input logic [CNT_W-1:0]  rxLevel,
  input logic [CNT_W-1:0]  txLevel,
  input fifoCmd_t          fifoCmd,
  input logic [2:0]        intStatus
);
  // R2 / R4: levels never exceed the storage
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= CNT_W'(DEPTH)) && (txLevel <= CNT_W'(DEPTH)));

  // R4: a put into a full receive FIFO raises overrun on the next edge
  assert_overrun_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxPut && (rxLevel == CNT_W'(DEPTH)) && !fifoCmd.rxFlush) |=> intStatus[0]);

  // R10: a flush strobe empties its FIFO on the next edge
  assert_rx_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoCmd.rxFlush |=> (rxLevel == '0));
  assert_tx_flush_R10: assert property (@(posedge clk) disable iff (!rstN)
    fifoCmd.txFlush |=> (txLevel == '0));

  // R8: overrun status stays set unless software clears it
  assert_sticky_ovr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[0] && !(wrEn && (addr == A_IST) && wrData[B_OVR])) |=> intStatus[0]);

  // R8: receive-complete status stays set unless software clears it
  assert_sticky_rc_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intStatus[1] && !(wrEn && (addr == A_IST) && wrData[B_RXDONE])) |=> intStatus[1]);
endmodule

bind ser_fifo_irq sfi_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rxPut(rxPut), .rxLevel(rxLevel), .txLevel(txLevel),
  .fifoCmd(fifoCmd), .intStatus(intStatus)
);

// File: tb/ser_fifo_irq_tb.sv
module ser_fifo_irq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic txAvail;
  logic [31:0] txHead;
  logic txTake = 1'b0, rxPut = 1'b0;
  logic [31:0] rxWord = '0;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ser_fifo_irq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .txAvail(txAvail), .txHead(txHead),
    .txTake(txTake), .rxPut(rxPut), .rxWord(rxWord), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic engPut(input logic [31:0] w);
    @(negedge clk);
    rxPut = 1'b1; rxWord = w;
    @(negedge clk);
    rxPut = 1'b0;
  endtask

  task automatic engTake(output logic avail, output logic [31:0] w);
    @(negedge clk);
    avail = txAvail; w = txHead;
    txTake = 1'b1;
    @(negedge clk);
    txTake = 1'b0;
  endtask

  task automatic cleanSlate();
    regWrite(6'h20, 32'h0000_1010);
    regWrite(6'h1C, 32'h0000_0019);
    regWrite(6'h18, 32'h0);
  endtask

  task automatic tReset();
    logic [31:0] v;
    check(32'(irq), 0, "R1 irq");
    check(32'(txAvail), 0, "R1 txAvail");
    regRead(6'h14, v); check(v, 0, "R1 status");
    regRead(6'h18, v); check(v, 0, "R1 enable");
    regRead(6'h1C, v); check(v, 0, "R1 int status");
    regRead(6'h20, v); check(v, 0, "R1 fifo ctrl");
  endtask

  task automatic tTxOrder();
    logic av; logic [31:0] w;
    cleanSlate();
    for (int i = 0; i < 9; i++) regWrite(6'h24, 32'hA000_0000 + 32'(i));
    for (int i = 0; i < 8; i++) begin
      engTake(av, w);
      check(32'(av), 1, "R2 avail");
      check(w, 32'hA000_0000 + 32'(i), "R2 order");
    end
    @(negedge clk);
    check(32'(txAvail), 0, "R2 ninth write dropped");
  endtask

  task automatic tRxOrder();
    logic [31:0] v;
    cleanSlate();
    regRead(6'h24, v); check(v, 0, "R3 empty read");
    for (int i = 0; i < 3; i++) engPut(32'hB000_0010 + 32'(i));
    regRead(6'h14, v); check(v, 1, "R3 not empty");
    for (int i = 0; i < 3; i++) begin
      regRead(6'h24, v); check(v, 32'hB000_0010 + 32'(i), "R3 order");
    end
    regRead(6'h14, v); check(v, 0, "R3 empty flag");
    regRead(6'h24, v); check(v, 0, "R3 empty read again");
    engPut(32'h0000_0055);
    regRead(6'h24, v); check(v, 32'h55, "R3 after empty read");
  endtask

  task automatic tOverrun();
    logic [31:0] v;
    cleanSlate();
    regWrite(6'h18, 32'h1);
    for (int i = 0; i < 9; i++) engPut(32'hC000_0000 + 32'(i));
    regRead(6'h1C, v); check(v & 32'h1, 1, "R4 overrun set");
    check(32'(irq), 1, "R9 irq on overrun");
    for (int i = 0; i < 8; i++) begin
      regRead(6'h24, v); check(v, 32'hC000_0000 + 32'(i), "R4 stored words kept");
    end
    regWrite(6'h1C, 32'h1);
    check(32'(irq), 0, "R8 clear drops irq");
    // set and clear in the same cycle: set wins
    for (int i = 0; i < 8; i++) engPut(32'(i));
    @(negedge clk);
    rxPut = 1'b1; rxWord = 32'hDEAD; wrEn = 1'b1; addr = 6'h1C; wrData = 32'h1;
    @(negedge clk);
    rxPut = 1'b0; wrEn = 1'b0;
    regRead(6'h1C, v); check(v & 32'h1, 1, "R8 set wins over clear");
  endtask

  task automatic tRxThr();
    logic [31:0] v;
    cleanSlate();
    regWrite(6'h20, 32'h0000_0013);
    engPut(1); engPut(2);
    regRead(6'h1C, v); check(v, 0, "R5 below threshold");
    engPut(3);
    regRead(6'h1C, v); check(v, 32'h208, "R5 R6 threshold reached");
    regRead(6'h24, v);
    regRead(6'h1C, v); check(v, 32'h008, "R6 level flag follows level");
    regWrite(6'h1C, 32'h1);
    regRead(6'h1C, v); check(v, 32'h008, "R8 zero bits no effect");
    regWrite(6'h18, 32'h8);
    check(32'(irq), 1, "R9 irq rx complete");
    regWrite(6'h1C, 32'h8);
    regRead(6'h1C, v); check(v, 0, "R8 rx complete cleared");
    regWrite(6'h20, 32'h0000_0010);
    for (int i = 0; i < 4; i++) engPut(32'(i));
    regRead(6'h1C, v); check(v, 0, "R5 zero threshold never sets");
    check(32'(irq), 0, "R9 no irq");
  endtask

  task automatic tTxThr();
    logic av; logic [31:0] w, v;
    cleanSlate();
    regWrite(6'h20, 32'h0000_1200);
    for (int i = 0; i < 4; i++) regWrite(6'h24, 32'(i));
    engTake(av, w);
    regRead(6'h1C, v); check(v & 32'h10, 0, "R7 above threshold");
    engTake(av, w);
    regRead(6'h1C, v); check(v & 32'h10, 32'h10, "R7 tx complete");
    check(32'(irq), 0, "R9 masked");
    regWrite(6'h18, 32'h10);
    check(32'(irq), 1, "R9 irq tx complete");
    regWrite(6'h1C, 32'h10);
    check(32'(irq), 0, "R8 tx clear");
  endtask

  task automatic tFlush();
    logic [31:0] v;
    cleanSlate();
    engPut(1); engPut(2); engPut(3);
    regWrite(6'h24, 32'h77);
    regWrite(6'h20, 32'h0000_1010);
    regRead(6'h14, v); check(v, 0, "R10 rx flushed");
    check(32'(txAvail), 0, "R10 tx flushed");
    regWrite(6'h20, 32'h0000_1305);
    regRead(6'h20, v); check(v, 32'h305, "R10 thresholds load, flush reads 0");
    // flush and put in the same cycle: flush wins
    engPut(9);
    @(negedge clk);
    rxPut = 1'b1; rxWord = 32'h99; wrEn = 1'b1; addr = 6'h20; wrData = 32'h10;
    @(negedge clk);
    rxPut = 1'b0; wrEn = 1'b0;
    regRead(6'h14, v); check(v, 0, "R10 flush beats put");
  endtask

  task automatic tUnmapped();
    logic [31:0] v;
    cleanSlate();
    regWrite(6'h04, 32'hFFFF_FFFF);
    regRead(6'h04, v); check(v, 0, "R11 unmapped read");
    regRead(6'h00, v); check(v, 0, "R11 offset zero");
    regWrite(6'h28, 32'hFFFF_FFFF);
    regRead(6'h18, v); check(v, 0, "R11 no side effect");
    check(32'(txAvail), 0, "R11 no push");
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tTxOrder();
    tRxOrder();
    tOverrun();
    tRxThr();
    tTxThr();
    tFlush();
    tUnmapped();
    done = 1'b1;
    summary();
  end
endmodule